// File: doc/BRIEF.md
# Programmable Supply Reset Sequencer

This block supervises the regulated output of a small bus-node supply and drives the node's active-low reset line. It has no analog parts. Comparator flags report whether the output has reached its initialization level and whether it sits above each of two reset thresholds, a lower one and an upper one. A strobe marks each oscillator tick. All timing is counted in these ticks.

When the output first passes the initialization level, the block reads a single configuration pin in two steps. First it samples the pin level, and that level picks the reset threshold. On the following tick it turns on a pull source that opposes that level, for exactly one tick. It then samples the pin again. If the pin kept its level, it is hard-tied and the long delay is used. If the level flipped, it is tied through a resistor and the short delay is used.

Reset is released once the chosen delay has run from the first sample. It is asserted again when the selected threshold is lost for a run of consecutive ticks. When the output recovers, the release delay restarts with the stored configuration. The pin is read again only after a new initialization request, which can come from power-on, recovery from thermal shutdown or a bus wake-up.

Top module: `rstseq_top`

## Requirements
- R1: After the asynchronous reset `rstN`, `resetN` is 0, both pull enables are 0 and `thrHigh` is 0.
- R2: The sampling tick is the first `oscTick` on which `vccAboveInit` is 1 while the block is waiting for initialization. On that tick `cfgPinLevel` is stored as `thrHigh`: 1 selects the upper threshold flag `vccAboveHi`, and 0 selects the lower flag `vccAboveLo`. Ticks with `vccAboveInit` at 0 leave the block waiting and do not sample the pin.
- R3: On the tick after the sampling tick, `pullUpEn` goes to 1 if `thrHigh` is 0, or `pullDnEn` goes to 1 if `thrHigh` is 1. The enable stays on until the next tick and is then cleared. The two enables are never 1 together.
- R4: When the probe ends, the pin is sampled again. If it matches the first sample, the long delay of `LONG_TICKS` ticks is chosen. If it differs, the short delay of `SHORT_TICKS` ticks is chosen. Both delays must be at least 3.
- R5: `resetN` rises on the D-th tick after the sampling tick, where D is the chosen delay.
- R6: `resetN` stays 0 through the probe and the delay count, and no pull enable is on while `resetN` is 1.
- R7: While reset is released, the selected threshold flag is checked on each tick. If it reads 0 on `REACT_TICKS` consecutive ticks, `resetN` falls on the last of those ticks. A shorter dip leaves `resetN` at 1.
- R8: While reset is released, the threshold flag that is not selected has no effect on `resetN`.
- R9: After a threshold drop, the first tick with `vccAboveInit` at 1 restarts the delay count. The stored configuration is kept and no probe is made. `resetN` rises on the D-th tick after that restart tick.
- R10: `initReq` in any state drives `resetN` to 0 on the next clock. The block then waits for a new sampling tick, and the pin is read again.
- R11: A tick with `vccAboveInit` at 0 during the delay count stops the count with `resetN` held at 0. Recovery then follows R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| oscTick | input | 1 | One-clock strobe for each oscillator tick |
| initReq | input | 1 | Start a new initialization (power-on, thermal recovery, bus wake-up) |
| vccAboveInit | input | 1 | Regulated output is above the initialization level |
| vccAboveLo | input | 1 | Regulated output is above the lower reset threshold |
| vccAboveHi | input | 1 | Regulated output is above the upper reset threshold |
| cfgPinLevel | input | 1 | Synchronized logic level of the configuration pin |
| resetN | output | 1 | Active-low reset to the node |
| pullUpEn | output | 1 | Enable for the configuration-pin pull-up source |
| pullDnEn | output | 1 | Enable for the configuration-pin pull-down source |
| thrHigh | output | 1 | 1 when the upper threshold is selected |

## Verification
The configuration pin is modelled in four ways: hard-tied low, hard-tied high, resistor to ground and resistor to supply. The resistor models follow the pull enables. These four separate threshold selection from delay selection, and they show whether the probe drives the correct source for exactly one tick. Threshold dips of random length below, at and above the reaction count show where a dip starts to assert reset. Dips on the flag that is not selected show that the flag selection is correct. Recovery after a drop, an interrupted delay count and initialization requests made while reset is released show that the configuration is kept without a new probe and is read again only on request.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_ARM   = 3'd1,
    ST_PROBE = 3'd2,
    ST_DELAY = 3'd3,
    ST_RUN   = 3'd4,
    ST_LOW   = 3'd5
  } seqState_t;

  typedef struct packed {
    logic sampleCfg;
    logic sampleProbe;
    logic clrCnt;
    logic incCnt;
  } seqStrobe_t;

endpackage

// File: rtl/rstseq_dp.sv
module rstseq_dp
  import rstseq_pkg::*;
#(
  parameter int SHORT_TICKS = 15,
  parameter int LONG_TICKS  = 100,
  parameter int REACT_TICKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  input  logic       cfgPinLevel,
  input  logic       vccAboveLo,
  input  logic       vccAboveHi,
  output logic       thrHigh,
  output logic       delayDone,
  output logic       reactDone,
  output logic       threshLost
);

  localparam int MAX_A = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int MAX_T = (MAX_A > REACT_TICKS) ? MAX_A : REACT_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic             longDelay;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] delayLast;

  // first sample selects the threshold, second sample picks the delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrHigh   <= 1'b0;
      longDelay <= 1'b1;
    end else begin
      if (strb.sampleCfg)   thrHigh   <= cfgPinLevel;
      if (strb.sampleProbe) longDelay <= (cfgPinLevel == thrHigh);
    end
  end

  // shared tick counter for release delay and reaction window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strb.clrCnt) cnt <= '0;
    else if (strb.incCnt) cnt <= cnt + 1'b1;
  end

  assign delayLast  = longDelay ? CNT_W'(LONG_TICKS - 1) : CNT_W'(SHORT_TICKS - 1);
  assign delayDone  = (cnt == delayLast);
  assign reactDone  = (cnt == CNT_W'(REACT_TICKS - 1));
  assign threshLost = thrHigh ? !vccAboveHi : !vccAboveLo;

  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sampleCfg |=> $stable(thrHigh)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(MAX_T)); // R5

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscTick,
  input  logic       initReq,
  input  logic       vccAboveInit,
  input  logic       thrHigh,
  input  logic       delayDone,
  input  logic       reactDone,
  input  logic       threshLost,
  output seqStrobe_t strb,
  output logic       resetN,
  output logic       pullUpEn,
  output logic       pullDnEn
);

  seqState_t state, nxt;

  always_comb begin
    nxt  = state;
    strb = '0;
    if (initReq) begin
      nxt         = ST_WAIT;
      strb.clrCnt = 1'b1;
    end else if (oscTick) begin
      case (state)
        ST_WAIT: if (vccAboveInit) begin
          nxt            = ST_ARM;
          strb.sampleCfg = 1'b1;
          strb.clrCnt    = 1'b1;
        end
        ST_ARM: if (!vccAboveInit) begin
          nxt         = ST_WAIT;
          strb.clrCnt = 1'b1;
        end else begin
          nxt         = ST_PROBE;
          strb.incCnt = 1'b1;
        end
        ST_PROBE: if (!vccAboveInit) begin
          nxt         = ST_WAIT;
          strb.clrCnt = 1'b1;
        end else begin
          nxt              = ST_DELAY;
          strb.sampleProbe = 1'b1;
          strb.incCnt      = 1'b1;
        end
        ST_DELAY: if (!vccAboveInit) begin
          nxt         = ST_LOW;
          strb.clrCnt = 1'b1;
        end else if (delayDone) begin
          nxt         = ST_RUN;
          strb.clrCnt = 1'b1;
        end else begin
          strb.incCnt = 1'b1;
        end
        ST_RUN: if (threshLost) begin
          if (reactDone) begin
            nxt         = ST_LOW;
            strb.clrCnt = 1'b1;
          end else begin
            strb.incCnt = 1'b1;
          end
        end else begin
          strb.clrCnt = 1'b1;
        end
        ST_LOW: if (vccAboveInit) begin
          nxt         = ST_DELAY;
          strb.clrCnt = 1'b1;
        end
        default: begin
          nxt         = ST_WAIT;
          strb.clrCnt = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= nxt;
  end

  assign resetN   = (state == ST_RUN);
  assign pullUpEn = (state == ST_PROBE) && !thrHigh;
  assign pullDnEn = (state == ST_PROBE) && thrHigh;

  logic pullAny;
  assign pullAny = pullUpEn || pullDnEn;

  AST_INIT_REQ_LOW: assert property (@(posedge clk) disable iff (!rstN)
    initReq |=> !resetN); // R10
  AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pullUpEn, pullDnEn})); // R3
  AST_PULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pullAny && !oscTick && !initReq) |=> pullAny); // R3
  AST_NO_PULL_RUN: assert property (@(posedge clk) disable iff (!rstN)
    resetN |-> !pullAny); // R6
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> $past(oscTick)); // R5
  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetN) |-> $past(initReq || (oscTick && threshLost))); // R7

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int SHORT_TICKS = 15,
  parameter int LONG_TICKS  = 100,
  parameter int REACT_TICKS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic oscTick,
  input  logic initReq,
  input  logic vccAboveInit,
  input  logic vccAboveLo,
  input  logic vccAboveHi,
  input  logic cfgPinLevel,
  output logic resetN,
  output logic pullUpEn,
  output logic pullDnEn,
  output logic thrHigh
);

  seqStrobe_t strb;
  logic       delayDone;
  logic       reactDone;
  logic       threshLost;

  rstseq_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .oscTick      (oscTick),
    .initReq      (initReq),
    .vccAboveInit (vccAboveInit),
    .thrHigh      (thrHigh),
    .delayDone    (delayDone),
    .reactDone    (reactDone),
    .threshLost   (threshLost),
    .strb         (strb),
    .resetN       (resetN),
    .pullUpEn     (pullUpEn),
    .pullDnEn     (pullDnEn)
  );

  rstseq_dp #(
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS),
    .REACT_TICKS (REACT_TICKS)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgPinLevel (cfgPinLevel),
    .vccAboveLo  (vccAboveLo),
    .vccAboveHi  (vccAboveHi),
    .thrHigh     (thrHigh),
    .delayDone   (delayDone),
    .reactDone   (reactDone),
    .threshLost  (threshLost)
  );

endmodule

// File: tb/rstseq_top_tb_top.sv
module rstseq_top_tb_top;

  localparam int SHORT_T = 15;
  localparam int LONG_T  = 100;
  localparam int REACT_T = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscTick = 1'b0;
  logic initReq = 1'b0;
  logic vccAboveInit = 1'b0;
  logic vccAboveLo = 1'b1;
  logic vccAboveHi = 1'b1;
  logic cfgPinLevel;
  logic resetN, pullUpEn, pullDnEn, thrHigh;

  logic pinTie = 1'b0;
  logic pinRes = 1'b0;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // pin model: hard tie ignores the pulls, resistor tie follows them
  assign cfgPinLevel = pinRes ? (pullUpEn ? 1'b1 : (pullDnEn ? 1'b0 : pinTie)) : pinTie;

  rstseq_top #(
    .SHORT_TICKS (SHORT_T),
    .LONG_TICKS  (LONG_T),
    .REACT_TICKS (REACT_T)
  ) dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .oscTick      (oscTick),
    .initReq      (initReq),
    .vccAboveInit (vccAboveInit),
    .vccAboveLo   (vccAboveLo),
    .vccAboveHi   (vccAboveHi),
    .cfgPinLevel  (cfgPinLevel),
    .resetN       (resetN),
    .pullUpEn     (pullUpEn),
    .pullDnEn     (pullDnEn),
    .thrHigh      (thrHigh)
  );

  function automatic bit expThr(input int mode);
    return mode[0];
  endfunction

  function automatic int expDelay(input int mode);
    return mode[1] ? SHORT_T : LONG_T;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tickOnce();
    @(negedge clk) oscTick = 1'b1;
    @(negedge clk) oscTick = 1'b0;
  endtask

  task automatic pulseInit();
    @(negedge clk) initReq = 1'b1;
    @(negedge clk) initReq = 1'b0;
    chk(resetN == 1'b0, "R10 reset low after init request", resetN, 0);
  endtask

  // count D ticks from a restart point, reset must rise only on the last
  task automatic countDelay(input int d, input int from, input string req);
    for (int k = from; k <= d; k++) begin
      tickOnce();
      chk(resetN == (k == d), req, resetN, (k == d));
      chk(!pullUpEn && !pullDnEn, "R6 no pull during delay", pullUpEn | pullDnEn, 0);
    end
  endtask

  task automatic runInit(input int mode);
    int d = expDelay(mode);
    pinTie = mode[0];
    pinRes = mode[1];
    vccAboveLo = 1'b1;
    vccAboveHi = 1'b1;
    vccAboveInit = 1'b0;
    tickOnce();
    chk(!pullUpEn && !pullDnEn && !resetN, "R2 no sample below init level", {pullUpEn, pullDnEn, resetN}, 0);
    vccAboveInit = 1'b1;
    tickOnce();
    chk(thrHigh == expThr(mode), "R2 threshold select", thrHigh, expThr(mode));
    chk(!pullUpEn && !pullDnEn, "R3 no pull on sampling tick", pullUpEn | pullDnEn, 0);
    tickOnce();
    chk(pullUpEn == !expThr(mode) && pullDnEn == expThr(mode), "R3 opposing pull on",
        {pullUpEn, pullDnEn}, {!expThr(mode), expThr(mode)});
    repeat (2) @(negedge clk);
    chk(pullUpEn == !expThr(mode) && pullDnEn == expThr(mode), "R3 pull held until tick",
        {pullUpEn, pullDnEn}, {!expThr(mode), expThr(mode)});
    chk(resetN == 1'b0, "R6 reset low in probe", resetN, 0);
    tickOnce();
    chk(!pullUpEn && !pullDnEn, "R3 pull off after one tick", pullUpEn | pullDnEn, 0);
    countDelay(d, 3, mode[1] ? "R4 R5 short delay release" : "R4 R5 long delay release");
  endtask

  task automatic recover(input int d);
    vccAboveLo = 1'b1;
    vccAboveHi = 1'b1;
    vccAboveInit = 1'b1;
    tickOnce();
    chk(resetN == 1'b0 && !pullUpEn && !pullDnEn, "R9 restart without probe",
        {resetN, pullUpEn, pullDnEn}, 0);
    countDelay(d, 1, "R9 release after restart");
  endtask

  task automatic runDip(input int mode, input int len, input bit onSel);
    bit sel = expThr(mode);
    if (onSel) begin
      vccAboveInit = 1'b0;
      if (sel) vccAboveHi = 1'b0; else vccAboveLo = 1'b0;
    end else begin
      if (sel) vccAboveLo = 1'b0; else vccAboveHi = 1'b0;
    end
    for (int i = 1; i <= len; i++) begin
      bit expLow = onSel && (i >= REACT_T);
      tickOnce();
      chk(resetN == !expLow, onSel ? "R7 selected dip" : "R8 unselected flag ignored",
          resetN, !expLow);
    end
    if (onSel && len >= REACT_T) begin
      recover(expDelay(mode));
    end else begin
      vccAboveLo = 1'b1;
      vccAboveHi = 1'b1;
      vccAboveInit = 1'b1;
      tickOnce();
      chk(resetN == 1'b1, "R7 short dip keeps release", resetN, 1);
    end
  endtask

  initial begin
    int unsigned seedV = $urandom(32'd2024);
    if (seedV == 0) nChk = 0;
    repeat (3) @(negedge clk);
    chk(resetN == 1'b0 && !pullUpEn && !pullDnEn && !thrHigh, "R1 reset state",
        {resetN, pullUpEn, pullDnEn, thrHigh}, 0);
    @(negedge clk) rstN = 1'b1;
    chk(resetN == 1'b0 && !thrHigh, "R1 after release", {resetN, thrHigh}, 0);

    // directed: every pin mode once
    for (int m = 0; m < 4; m++) begin
      pulseInit();
      runInit(m);
    end

    // directed: dip exactly at and just under the reaction count
    runDip(3, REACT_T - 1, 1'b1);
    runDip(3, REACT_T, 1'b1);

    // directed: delay count interrupted by loss of init level
    pulseInit();
    pinTie = 1'b0;
    pinRes = 1'b1;
    vccAboveInit = 1'b1;
    repeat (5) tickOnce();
    vccAboveInit = 1'b0;
    tickOnce();
    chk(resetN == 1'b0, "R11 count stopped", resetN, 0);
    repeat (SHORT_T) tickOnce();
    chk(resetN == 1'b0, "R11 held low without init level", resetN, 0);
    recover(SHORT_T);

    // directed: init request while released re-reads the pin
    @(negedge clk) initReq = 1'b1;
    @(negedge clk) initReq = 1'b0;
    chk(resetN == 1'b0, "R10 request drops reset", resetN, 0);
    runInit(1);

    // random mix
    for (int it = 0; it < 10; it++) begin
      int mode = int'($urandom % 4);
      pulseInit();
      runInit(mode);
      for (int j = 0; j < 3; j++) begin
        int len = 1 + int'($urandom % 6);
        bit onSel = 1'($urandom % 2);
        runDip(mode, len, onSel);
      end
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++;
      nBad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule